// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block combines several reset requests into one synchronous internal reset, `sys_rst`, and keeps an 8-bit cause register that software reads and writes. The requests are a flash access violation, two qualified real-time-clock events (oscillator failure and alarm match), a software trigger written to the register, and the external reset pin. The analog detectors and the real-time clock are outside the block. Their events arrive as digital level or pulse inputs together with their qualifying enable flags.

Once a request is taken, `sys_rst` stays high for a fixed number of clock cycles, `HOLD_CYC` (default 16), and is then released synchronously. For the pin, the hold runs from the point at which the synchronized pin level returns high. The pin is only ever sampled: the block has no path that drives it, so internal resets leave it alone. The real-time-clock path is independent of the low-power indication, so it still resets a sleeping core. Register writes are ignored while the core is in low power or in reset.

The controller is a three-state machine. `ST_HOLD` counts the hold window and is also the state after power-on. `ST_PIN` follows the synchronized pin while it is low. `ST_RUN` is normal operation. The transitions are:
- RUN→PIN, HOLD→PIN: the pin is low.
- RUN→HOLD: an internal request wins.
- HOLD→RUN: the count reaches `HOLD_CYC-1`.
- PIN→HOLD: the pin is released.

Top module: `rstc_top`

## Requirements
- R1: While `por_n` is low, `reg_rdata` reads 0x00 and `sys_rst` is 1. After `por_n` rises, `sys_rst` stays 1 for exactly `HOLD_CYC` cycles and then falls.
- R2: An internal request taken in `ST_RUN` raises `sys_rst` at the next clock edge. `sys_rst` then stays high for exactly `HOLD_CYC` cycles.
- R3: A low level on `pin_rst_n` is synchronized through `SYNC_STAGES` flops and holds `sys_rst` high while the pin stays low. After the pin is released, `sys_rst` stays high for `SYNC_STAGES + HOLD_CYC` sampled cycles. After a pin reset the register reads 0x01: bit 0 is the pin flag and the enable bit is cleared.
- R4: A `flash_err` pulse resets the system and sets bit 6 (flash flag) as the only cause flag.
- R5: A real-time-clock event resets the system only when enable bit 7 is 1 and the event is qualified, that is `(osc_fail & osc_det_en) | (alarm_hit & alarm_en)`. It sets bit 5 (clock flag) as the only cause flag.
- R6: The real-time-clock reset of R5 behaves the same whether `low_power` is 0 or 1.
- R7: A write with bit 4 = 1 forces a reset, and bit 4 (software flag) then reads 1 as the only cause flag.
- R8: When requests coincide, only one flag is set. The order of precedence is pin, then flash, then clock, then software. Every new reset clears the earlier cause flags.
- R9: Bit 7 (clock reset enable) is taken from every accepted write. It keeps its value through flash, clock and software resets.
- R10: Writes made while `low_power` = 1 or while `sys_rst` = 1 change nothing and trigger nothing. Write bits 6..0 other than bit 4 are never stored. Bits 3..1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_rst_n | input | 1 | External reset pin level, active low, asynchronous |
| flash_err | input | 1 | Flash access violation request |
| osc_fail | input | 1 | Clock oscillator below threshold |
| osc_det_en | input | 1 | Missing-clock detector enabled |
| alarm_hit | input | 1 | Clock timer equals alarm value |
| alarm_en | input | 1 | Alarm enabled |
| low_power | input | 1 | Core in suspend or sleep |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data: {en, flash, clock, sw, 000, pin} |
| sys_rst | output | 1 | Internal system reset, active high |

## Verification
Two paths can fall in the same cycle: the taking of a new reset cause, and the register write that carries the enable bit and the software trigger. The bench sweeps all eight combinations of flash, clock and software requests, each as a one-cycle pulse in the same cycle. For each combination it checks the hold length, the single surviving flag and the enable bit. A second case lands a pin assertion, synchronized, on the same edge as all three internal requests, and the bench expects the pin flag alone. A last case places a write inside the hold window and expects it to have no effect.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_PIN  = 2'd1,
        ST_RUN  = 2'd2
    } rstc_state_e;

    // register bit positions
    localparam int BIT_EN    = 7;
    localparam int BIT_FLASH = 6;
    localparam int BIT_CLK   = 5;
    localparam int BIT_SW    = 4;
    localparam int BIT_PIN   = 0;

    // cause vector order (index)
    localparam int CS_PIN   = 0;
    localparam int CS_SW    = 1;
    localparam int CS_CLK   = 2;
    localparam int CS_FLASH = 3;
    localparam int CS_W     = 4;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n,
    output logic pin_low
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain[g] <= 1'b1;
                    else        chain[g] <= pin_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign pin_low = ~chain[STAGES-1];
endmodule

// File: rtl/rstc_arb.sv
module rstc_arb
    import rstc_pkg::*;
(
    input  logic            flash_err,
    input  logic            osc_fail,
    input  logic            osc_det_en,
    input  logic            alarm_hit,
    input  logic            alarm_en,
    input  logic            clk_rst_en,
    input  logic            sw_req,
    output logic [CS_W-1:0] cause,
    output logic            any_req
);
    logic clk_evt;

    // clock path is deliberately not gated by low power
    assign clk_evt = clk_rst_en & ((osc_fail & osc_det_en) | (alarm_hit & alarm_en));

    always_comb begin
        cause = '0;
        if (flash_err)    cause[CS_FLASH] = 1'b1;
        else if (clk_evt) cause[CS_CLK]   = 1'b1;
        else if (sw_req)  cause[CS_SW]    = 1'b1;
    end

    assign any_req = flash_err | clk_evt | sw_req;
endmodule

// File: rtl/rstc_fsm.sv
module rstc_fsm
    import rstc_pkg::*;
#(
    parameter int HOLD_CYC = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_low,
    input  logic int_req,
    output logic sys_rst,
    output logic in_run,
    output logic take_pin,
    output logic take_int
);
    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    rstc_state_e state, state_nx;
    logic [CW-1:0] cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (pin_low)      state_nx = ST_PIN;
                else if (int_req) state_nx = ST_HOLD;
            end
            ST_HOLD: begin
                if (pin_low)          state_nx = ST_PIN;
                else if (cnt == LAST) state_nx = ST_RUN;
            end
            ST_PIN: begin
                if (!pin_low) state_nx = ST_HOLD;
            end
            default: state_nx = ST_HOLD;
        endcase
    end

    // state register and hold counter
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= ST_HOLD;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_HOLD && state_nx == ST_HOLD) cnt <= cnt + 1'b1;
            else                                          cnt <= '0;
        end
    end

    // registered output
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sys_rst <= 1'b1;
        else        sys_rst <= (state_nx != ST_RUN);
    end

    assign in_run   = (state == ST_RUN);
    assign take_pin = pin_low && (state != ST_PIN);
    assign take_int = (state == ST_RUN) && !pin_low && int_req;
endmodule

// File: rtl/rstc_status.sv
module rstc_status
    import rstc_pkg::*;
(
    input  logic            clk,
    input  logic            por_n,
    input  logic            take_pin,
    input  logic            take_int,
    input  logic [CS_W-1:0] cause,
    input  logic            wr_ok,
    input  logic [7:0]      wdata,
    output logic            clk_rst_en,
    output logic [7:0]      rdata
);
    logic [CS_W-1:0] flags;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            clk_rst_en <= 1'b0;
            flags      <= '0;
        end else if (take_pin) begin
            clk_rst_en     <= 1'b0;
            flags          <= '0;
            flags[CS_PIN]  <= 1'b1;
        end else begin
            if (take_int) flags      <= cause;
            if (wr_ok)    clk_rst_en <= wdata[BIT_EN];
        end
    end

    always_comb begin
        rdata            = '0;
        rdata[BIT_EN]    = clk_rst_en;
        rdata[BIT_FLASH] = flags[CS_FLASH];
        rdata[BIT_CLK]   = flags[CS_CLK];
        rdata[BIT_SW]    = flags[CS_SW];
        rdata[BIT_PIN]   = flags[CS_PIN];
    end
endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int HOLD_CYC    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       pin_rst_n,
    input  logic       flash_err,
    input  logic       osc_fail,
    input  logic       osc_det_en,
    input  logic       alarm_hit,
    input  logic       alarm_en,
    input  logic       low_power,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       sys_rst
);
    logic            pin_low;
    logic            in_run, take_pin, take_int, any_req;
    logic            clk_rst_en, wr_ok, sw_req;
    logic [CS_W-1:0] cause;

    assign wr_ok  = reg_wr && in_run && !low_power;
    assign sw_req = wr_ok && reg_wdata[BIT_SW];

    rstc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .por_n(por_n), .pin_n(pin_rst_n), .pin_low(pin_low)
    );

    rstc_arb u_arb (
        .flash_err(flash_err), .osc_fail(osc_fail), .osc_det_en(osc_det_en),
        .alarm_hit(alarm_hit), .alarm_en(alarm_en), .clk_rst_en(clk_rst_en),
        .sw_req(sw_req), .cause(cause), .any_req(any_req)
    );

    rstc_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk(clk), .por_n(por_n), .pin_low(pin_low), .int_req(any_req),
        .sys_rst(sys_rst), .in_run(in_run), .take_pin(take_pin), .take_int(take_int)
    );

    rstc_status u_status (
        .clk(clk), .por_n(por_n), .take_pin(take_pin), .take_int(take_int),
        .cause(cause), .wr_ok(wr_ok), .wdata(reg_wdata),
        .clk_rst_en(clk_rst_en), .rdata(reg_rdata)
    );
endmodule

// File: rtl/rstc_chk.sv
module rstc_chk (
    input logic       clk,
    input logic       por_n,
    input logic       pin_rst_n,
    input logic       low_power,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       sys_rst
);
    AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(reg_rdata[6:0])); // R8

    AST_EN_SET_BY_WRITE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(reg_rdata[7]) |-> $past(reg_wr && reg_wdata[7] && !low_power && !sys_rst)); // R9

    AST_CLK_NEEDS_EN: assert property (@(posedge clk) disable iff (!por_n)
        $rose(reg_rdata[5]) |-> $past(reg_rdata[7])); // R5

    AST_SW_FROM_WRITE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(reg_rdata[4]) |-> $past(reg_wr && reg_wdata[4] && !low_power)); // R7

    AST_FLAG_WITH_RST: assert property (@(posedge clk) disable iff (!por_n)
        $rose(reg_rdata[6]) |-> sys_rst); // R4

    AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst) |=> sys_rst); // R2

    AST_PIN_RELEASED: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sys_rst) |-> $past(pin_rst_n)); // R3

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        reg_rdata[3:1] == 3'b000); // R10
endmodule

bind rstc_top rstc_chk u_chk (
    .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n), .low_power(low_power),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_rst(sys_rst)
);

// File: tb/test_rstc_top.sv
`timescale 1ns/1ps
module test_rstc_top;
    localparam int HOLD = 16;
    localparam int SYNC = 2;

    logic clk = 0, por_n = 0, pin_rst_n = 1;
    logic flash_err = 0, osc_fail = 0, osc_det_en = 0, alarm_hit = 0, alarm_en = 0;
    logic low_power = 0, reg_wr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic sys_rst;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    rstc_top #(.HOLD_CYC(HOLD), .SYNC_STAGES(SYNC)) i_rstc_top (
        .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n), .flash_err(flash_err),
        .osc_fail(osc_fail), .osc_det_en(osc_det_en), .alarm_hit(alarm_hit),
        .alarm_en(alarm_en), .low_power(low_power), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_rst(sys_rst)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mkreg(input logic en, fl, ck, sw, pn);
        return {en, fl, ck, sw, 3'b000, pn};
    endfunction

    // one-cycle stimulus, then count high samples of sys_rst
    task automatic pulse(input logic f, o, m, a, ae, w, input logic [7:0] wd, output int len);
        @(negedge clk);
        flash_err = f; osc_fail = o; osc_det_en = m; alarm_hit = a; alarm_en = ae;
        reg_wr = w; reg_wdata = wd;
        @(negedge clk);
        flash_err = 0; osc_fail = 0; osc_det_en = 0; alarm_hit = 0; alarm_en = 0;
        reg_wr = 0; reg_wdata = 0;
        len = 0;
        while (sys_rst && len < 200) begin len++; @(negedge clk); end
    endtask

    task automatic wr(input logic [7:0] d);
        int l;
        pulse(0, 0, 0, 0, 0, 1, d, l);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int len;
        logic [7:0] prev, expv;
        repeat (3) @(negedge clk);
        chk("R1 sys_rst in por", sys_rst, 1);
        chk("R1 rdata in por", reg_rdata, 0);
        por_n = 1;
        len = 0;
        while (sys_rst && len < 200) begin len++; @(negedge clk); end
        chk("R1 por hold length", len, HOLD);
        chk("R1 rdata after por", reg_rdata, 0);

        // enable write, no reset
        pulse(0, 0, 0, 0, 0, 1, 8'h80, len);
        chk("R9 enable write no reset", len, 0);
        chk("R9 enable set", reg_rdata, 8'h80);

        // coincidence sweep of flash / clock / software
        for (int mm = 0; mm < 8; mm++) begin
            logic f, c, s;
            f = mm[0]; c = mm[1]; s = mm[2];
            pulse(f, c, c, 0, 0, s, s ? 8'h90 : 8'h00, len);
            chk($sformatf("R2 hold len mask %0d", mm), len, (mm != 0) ? HOLD : 0);
            if (mm != 0)
                chk($sformatf("R8 R4 R7 flags mask %0d", mm), reg_rdata,
                    mkreg(1, f, !f && c, !f && !c && s, 0));
        end

        // clock qualifier / enable / low-power sweep
        for (int en = 0; en < 2; en++)
            for (int lp = 0; lp < 2; lp++)
                for (int q = 0; q < 16; q++) begin
                    logic fire;
                    wr(en ? 8'h80 : 8'h00);
                    low_power = lp[0];
                    prev = reg_rdata;
                    fire = en[0] & ((q[0] & q[1]) | (q[2] & q[3]));
                    pulse(0, q[0], q[1], q[2], q[3], 0, 0, len);
                    chk($sformatf("R5 R6 clk reset en%0d lp%0d q%0d", en, lp, q), len, fire ? HOLD : 0);
                    expv = fire ? mkreg(en[0], 0, 1, 0, 0) : prev;
                    chk($sformatf("R5 R6 clk flags en%0d lp%0d q%0d", en, lp, q), reg_rdata, expv);
                    low_power = 0;
                end

        // low-power write ignored
        wr(8'h80);
        low_power = 1;
        prev = reg_rdata;
        pulse(0, 0, 0, 0, 0, 1, 8'h10, len);
        chk("R10 lp write no reset", len, 0);
        chk("R10 lp write no change", reg_rdata, prev);
        low_power = 0;

        // unstored bits
        pulse(0, 0, 0, 0, 0, 1, 8'h6E, len);
        chk("R10 other bits no reset", len, 0);
        chk("R10 other bits not stored", reg_rdata, {1'b0, prev[6:0]});

        // write during reset ignored
        wr(8'h80);
        @(negedge clk); flash_err = 1;
        @(negedge clk); flash_err = 0; reg_wr = 1; reg_wdata = 8'h10;
        @(negedge clk); reg_wr = 0; reg_wdata = 0;
        while (sys_rst) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R10 write in reset ignored", reg_rdata, 8'hC0);

        // pin reset alone
        @(negedge clk); pin_rst_n = 0;
        repeat (6) @(negedge clk);
        chk("R3 sys_rst while pin low", sys_rst, 1);
        pin_rst_n = 1;
        len = 0;
        @(negedge clk);
        while (sys_rst && len < 200) begin len++; @(negedge clk); end
        chk("R3 pin release length", len, SYNC + HOLD);
        chk("R3 pin flags", reg_rdata, 8'h01);

        // pin coincident with all internal requests
        wr(8'h80);
        @(negedge clk); pin_rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        flash_err = 1; osc_fail = 1; osc_det_en = 1; reg_wr = 1; reg_wdata = 8'h90;
        @(negedge clk);
        flash_err = 0; osc_fail = 0; osc_det_en = 0; reg_wr = 0; reg_wdata = 0;
        repeat (3) @(negedge clk);
        pin_rst_n = 1;
        while (sys_rst) @(negedge clk);
        chk("R8 pin wins coincidence", reg_rdata, 8'h01);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule